// File: doc/BRIEF.md
# Per-Channel Two-Bit Fault Diagnosis Register

This block holds a two-bit fault code for each of the output channels of an octal low-side driver. It also drives one active-low summary fault line. Each channel reports three raw condition flags and its on/off state:

- overload, which covers current limit, short to supply and over-temperature;
- open load;
- short to ground.

A raw flag only counts when it fits the channel state. Overload counts only while the channel is on. Open load and short to ground count only while the channel is off.

A flag must stay present for a programmable number of clock cycles before its code is stored. A later qualified fault replaces the stored code. Codes stay stored after the raw flag goes away.

The serial interface block reads the packed 16-bit word continuously. It sends a one-cycle clear pulse when a frame ends with a valid command. That pulse returns every code to normal and restarts every filter timer. A frame that is not valid sends no pulse, so all stored codes stay as they are. The word and the flag are plain levels with no handshake, because the serial block samples them whenever it needs them.

Top module: `diag_register`

## Requirements
- R1: While `rst_n` is low, and after it is released with no condition present, `diag_word` reads 16'hFFFF and `fault_n` is 1.
- R2: The code values are 2'b11 for normal, 2'b10 for overload, 2'b01 for open load and 2'b00 for short to ground.
- R3: A condition is stored only when it has been sampled present on FILT_CYCLES+1 consecutive clock edges. The stored code is visible after the edge that completes that run. If the condition is absent for even one sampled edge, the count starts again.
- R4: Open load and short to ground are counted only while `ch_on` for that channel is 0. Overload is counted only while `ch_on` is 1. A flag raised in the other state leaves the word at 16'hFFFF.
- R5: If conditions on one channel qualify on the same edge, the code chosen is overload first, then short to ground (00), then open load (01).
- R6: A newly qualified fault replaces the code already stored for that channel. For example, 00 stored and then open load qualifying gives 01.
- R7: `fault_n` is 0 whenever any channel's code differs from 2'b11, and 1 otherwise.
- R8: A one-cycle `clr_valid` pulse sets every code to 2'b11 after that edge and restarts all filter timers. A condition that stays present is therefore stored again only after a further FILT_CYCLES+1 edges.
- R9: Without a `clr_valid` pulse, a stored code stays unchanged after its condition disappears. This is the behaviour when an invalid frame ends.
- R10: Channel n (counting from 0) occupies bits 2n+1:2n of `diag_word`. The top channel is at bits 15:14 and the first channel is at bits 1:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset or sleep; clears all codes |
| ch_on | input | NUM_CH | Per-channel output state, 1 = on |
| cond_ovl | input | NUM_CH | Raw overload / over-temperature flags |
| cond_open | input | NUM_CH | Raw open-load flags |
| cond_shg | input | NUM_CH | Raw short-to-ground flags |
| clr_valid | input | 1 | One-cycle pulse when a valid serial frame ends |
| diag_word | output | 2*NUM_CH | Packed per-channel codes |
| fault_n | output | 1 | Active-low summary fault flag |

## Verification
Some rules are checked by the assertions on every cycle:

- a filter can only qualify a condition that was present on the previous edge;
- a clear pulse always leaves normal codes and a released flag;
- the flag stays low until a clear arrives;
- a code can only move to an off-state fault while the channel was off, or to overload while it was on;
- codes hold while nothing qualifies.

Other properties need the bench's directed scenarios:

- the exact filter length;
- the restart after a broken run or a clear;
- priority between conditions qualifying on the same edge;
- overwriting of one fault by another;
- the bit position of each channel in the packed word.

// File: rtl/diag_pkg.sv
package diag_pkg;
  typedef enum logic [1:0] {
    DG_SHG  = 2'b00,
    DG_OPEN = 2'b01,
    DG_OVL  = 2'b10,
    DG_OK   = 2'b11
  } diag_code_e;

  localparam int unsigned NUM_COND = 3;
  localparam int unsigned IDX_OVL  = 0;
  localparam int unsigned IDX_SHG  = 1;
  localparam int unsigned IDX_OPEN = 2;
endpackage

// File: rtl/diag_filter.sv
module diag_filter #(
  parameter int unsigned FILT_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic cond,
  output logic qual
);
  localparam int unsigned CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] LIM = CW'(FILT_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (restart || !cond)  cnt_q <= '0;
    else if (cnt_q != LIM)      cnt_q <= cnt_q + 1'b1;
  end

  assign qual = cond && (cnt_q == LIM);

  // R3: a qualification needs the condition seen on the previous edge too
  a_r3_qual_has_history: assert property (@(posedge clk) disable iff (!rst_n)
    qual |-> $past(cond));
endmodule

// File: rtl/diag_slot.sv
module diag_slot
  import diag_pkg::*;
#(
  parameter int unsigned FILT_CYCLES = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ch_on,
  input  logic       ovl,
  input  logic       open_ld,
  input  logic       shg,
  input  logic       clr,
  output diag_code_e code
);
  logic [NUM_COND-1:0] gated;
  logic [NUM_COND-1:0] qual;
  diag_code_e          code_q;
  diag_code_e          code_d;

  // state gating (R4)
  assign gated[IDX_OVL]  = ovl && ch_on;
  assign gated[IDX_SHG]  = shg && !ch_on;
  assign gated[IDX_OPEN] = open_ld && !ch_on;

  for (genvar k = 0; k < NUM_COND; k++) begin : g_filt
    diag_filter #(.FILT_CYCLES(FILT_CYCLES)) filt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (clr),
      .cond    (gated[k]),
      .qual    (qual[k])
    );
  end

  // priority and overwrite (R5, R6); clear wins (R8)
  always_comb begin
    code_d = code_q;
    if (clr)                  code_d = DG_OK;
    else if (qual[IDX_OVL])   code_d = DG_OVL;
    else if (qual[IDX_SHG])   code_d = DG_SHG;
    else if (qual[IDX_OPEN])  code_d = DG_OPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= DG_OK;
    else        code_q <= code_d;
  end

  assign code = code_q;

  a_r8_clear_to_ok: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (code == DG_OK));

  a_r4_off_codes: assert property (@(posedge clk) disable iff (!rst_n)
    ((code != $past(code)) && (code == DG_OPEN || code == DG_SHG)) |-> !$past(ch_on));

  a_r4_on_code: assert property (@(posedge clk) disable iff (!rst_n)
    ((code != $past(code)) && (code == DG_OVL)) |-> $past(ch_on));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (qual == '0)) |=> $stable(code));
endmodule

// File: rtl/diag_register.sv
module diag_register
  import diag_pkg::*;
#(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned FILT_CYCLES = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_CH-1:0]     ch_on,
  input  logic [NUM_CH-1:0]     cond_ovl,
  input  logic [NUM_CH-1:0]     cond_open,
  input  logic [NUM_CH-1:0]     cond_shg,
  input  logic                  clr_valid,
  output logic [2*NUM_CH-1:0]   diag_word,
  output logic                  fault_n
);
  diag_code_e codes [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    diag_slot #(.FILT_CYCLES(FILT_CYCLES)) slot_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .ch_on   (ch_on[i]),
      .ovl     (cond_ovl[i]),
      .open_ld (cond_open[i]),
      .shg     (cond_shg[i]),
      .clr     (clr_valid),
      .code    (codes[i])
    );
    // R10: channel i at bits 2i+1:2i
    assign diag_word[2*i +: 2] = codes[i];
  end

  // any code other than 11 carries a zero bit (R7)
  assign fault_n = &diag_word;

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_n && !clr_valid) |=> !fault_n);

  a_r8_flag_release: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |=> fault_n);
endmodule

// File: tb/diag_register_tb.sv
module diag_register_tb_top;
  localparam int NCH = 8;
  localparam int F   = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] ch_on = '0, cond_ovl = '0, cond_open = '0, cond_shg = '0;
  logic           clr_valid = 1'b0;
  logic [15:0]    diag_word;
  logic           fault_n;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  diag_register #(.NUM_CH(NCH), .FILT_CYCLES(F)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_on(ch_on), .cond_ovl(cond_ovl),
    .cond_open(cond_open), .cond_shg(cond_shg), .clr_valid(clr_valid),
    .diag_word(diag_word), .fault_n(fault_n));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] word_with(input int ch, input logic [1:0] c);
    logic [15:0] w = 16'hFFFF;
    w[2*ch +: 2] = c;
    return w;
  endfunction

  task automatic do_clear();
    cond_ovl = '0; cond_open = '0; cond_shg = '0;
    clr_valid = 1'b1;
    tick(1);
    clr_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk(diag_word, 16'hFFFF, "R1 word in reset");
    chk({15'd0, fault_n}, 16'd1, "R1 flag in reset");
    rst_n = 1'b1;
    tick(3);
    chk(diag_word, 16'hFFFF, "R1 word after release");
    chk({15'd0, fault_n}, 16'd1, "R7 flag clear with no fault");
  endtask

  task automatic t_filter();
    ch_on = '0;
    cond_open[2] = 1'b1;
    tick(F);
    chk(diag_word, 16'hFFFF, "R3 not stored at filter length");
    tick(1);
    chk(diag_word, word_with(2, 2'b01), "R3 R2 open load stored");
    chk({15'd0, fault_n}, 16'd0, "R7 flag low on fault");
    clr_valid = 1'b1;
    tick(1);
    clr_valid = 1'b0;
    chk(diag_word, 16'hFFFF, "R8 clear returns normal");
    tick(F);
    chk(diag_word, 16'hFFFF, "R8 timer restarted after clear");
    tick(1);
    chk(diag_word, word_with(2, 2'b01), "R8 re-stored after full window");
    do_clear();
    cond_open[2] = 1'b1;
    tick(F);
    cond_open[2] = 1'b0;
    tick(1);
    cond_open[2] = 1'b1;
    tick(F);
    chk(diag_word, 16'hFFFF, "R3 broken run restarts count");
    tick(1);
    chk(diag_word, word_with(2, 2'b01), "R3 stored after new full run");
    do_clear();
  endtask

  task automatic t_gate();
    ch_on[0] = 1'b1;
    cond_open[0] = 1'b1; cond_shg[0] = 1'b1;
    tick(F + 3);
    chk(diag_word, 16'hFFFF, "R4 off-state flags ignored while on");
    cond_open[0] = 1'b0; cond_shg[0] = 1'b0;
    ch_on[0] = 1'b0;
    cond_ovl[0] = 1'b1;
    tick(F + 3);
    chk(diag_word, 16'hFFFF, "R4 overload ignored while off");
    ch_on[0] = 1'b1;
    tick(F + 1);
    chk(diag_word, word_with(0, 2'b10), "R4 R2 overload stored while on");
    do_clear();
    ch_on = '0;
  endtask

  task automatic t_priority();
    cond_open[7] = 1'b1; cond_shg[7] = 1'b1;
    tick(F + 1);
    chk(diag_word, word_with(7, 2'b00), "R5 short to ground beats open load");
    do_clear();
  endtask

  task automatic t_overwrite();
    cond_shg[3] = 1'b1;
    tick(F + 1);
    chk(diag_word, word_with(3, 2'b00), "R6 first fault stored");
    cond_shg[3] = 1'b0; cond_open[3] = 1'b1;
    tick(F + 1);
    chk(diag_word, word_with(3, 2'b01), "R6 newer fault overwrites");
    cond_open[3] = 1'b0;
    tick(5);
    chk(diag_word, word_with(3, 2'b01), "R9 code held without clear");
    chk({15'd0, fault_n}, 16'd0, "R9 flag held without clear");
    do_clear();
    chk({15'd0, fault_n}, 16'd1, "R7 flag released after clear");
  endtask

  task automatic t_layout();
    logic [15:0] e;
    ch_on[1] = 1'b1; cond_ovl[1] = 1'b1;
    cond_open[4] = 1'b1;
    cond_shg[6] = 1'b1;
    tick(F + 1);
    e = 16'hFFFF;
    e[3:2] = 2'b10; e[9:8] = 2'b01; e[13:12] = 2'b00;
    chk(diag_word, e, "R10 packed positions of several channels");
    do_clear();
    ch_on = '0;
    chk(diag_word, 16'hFFFF, "R8 full clear of several channels");
  endtask

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    t_reset();
    t_filter();
    t_gate();
    t_priority();
    t_overwrite();
    t_layout();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule